// File: doc/BRIEF.md
# Snapshot-Read Cycle Counter

This block keeps a free-running count of clock cycles and makes it visible to software through a narrow register window on a simple synchronous bus. Bytes of the count are never read directly. Software first writes a control word that copies the live count into a snapshot register. It then fetches that snapshot one byte per read. All the bytes therefore belong to the same instant, even when a carry ripples through the live counter between two reads.

The same control word can also clear the counter and keep it at zero. This lets software start a measurement from a known point. Reads and writes at the base offset do different things: a write there reaches the control logic, and a read there returns the lowest snapshot byte. Read data is registered and comes back zero-extended to 32 bits. An access to an offset that does not exist returns zero and raises a one-cycle error flag.

Top module: `cyc_snap_counter`

## Requirements
- R1: While it is not held, the counter advances by one on every clock edge. After all ones it wraps to zero.
- R2: While `rst_n` is low at a clock edge, the counter and the snapshot are cleared, `bus_rdata` and `bus_err` are zero, and the hold is released. The first edge after reset leaves a count of one.
- R3: A write to offset 0x00 with data bit 0 set clears the counter at that edge and keeps it at zero. A write to offset 0x00 with bit 0 clear releases the counter, and the release edge leaves a count of one.
- R4: A write to offset 0x00 with data bit 1 set loads the snapshot with the count as it stood before that edge. With bit 1 clear, the snapshot keeps its value.
- R5: If bits 0 and 1 are set in the same write, the snapshot receives the count from before the clear, and the counter is zero after that edge.
- R6: A read at offset 4*k, for k from 0 to ceil(CNT_W/8)-1, returns byte k of the snapshot (bits [8k+7:8k]) in `bus_rdata[7:0]`. Bits [31:8] are zero, and snapshot bits above CNT_W-1 read as zero.
- R7: Reads return only snapshot contents, never the live count. Repeated reads with no capture between them return the same value while the counter runs.
- R8: `bus_rdata` and `bus_err` change on the clock edge after the one that samples `bus_rd`. In a cycle that follows no read, `bus_rdata` is zero.
- R9: Some accesses are undefined: a read at an unaligned offset or an offset past the last byte, and a write to any offset other than 0x00. Such an access gives zero read data and `bus_err` high for exactly one cycle, and it changes neither the counter nor the snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset from the block base |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; only bits [1:0] act |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, byte in [7:0] |
| bus_err | output | 1 | One-cycle flag for an undefined access |

## Verification
The bench builds two copies side by side on the same bus stimulus. One uses the default 64-bit width, so it exercises all eight byte offsets and the zero upper bytes. The other uses a 12-bit width. With only two byte offsets, its readback reports the third and higher offsets as errors, and its count wraps after 4096 cycles. That brings the all-ones-to-zero wrap within reach of a short run, and the wrapped value can be checked against the wide copy on the same cycle.

// File: rtl/csc_pkg.sv
// Shared types for the snapshot-read cycle counter.
// Assumes: the bus delivers one access per cycle; offsets are byte offsets.
package csc_pkg;

    // Spacing in bytes between two readback registers.
    localparam int unsigned REG_STRIDE = 4;

    // Decoded control write, handed from the decoder to counter and snapshot.
    typedef struct packed {
        logic ctrl_wr;   // legal write to the control offset this cycle
        logic hold_req;  // requested hold state (data bit 0)
        logic cap_req;   // capture request (data bit 1 of a legal write)
    } csc_cmd_t;

endpackage

// File: rtl/csc_decode.sv
// Address decoder: splits a bus access into a control command, a readback
// index and an error indication. Purely combinational.
// Assumes: offset 0x00 is the only writable offset; readback offsets are
// aligned to csc_pkg::REG_STRIDE.
module csc_decode
    import csc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BYTES = 8,
    parameter int IDX_W     = 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output csc_cmd_t          cmd,
    output logic              rd_ok,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              acc_err
);

    localparam int SHIFT = $clog2(REG_STRIDE);

    logic wr_ok;
    logic unused_wdata;

    // Reserved write data bits have no function.
    assign unused_wdata = ^bus_wdata[31:2];

    // Classify the access and form the control command.
    always_comb begin
        wr_ok        = (bus_addr == '0);
        rd_ok        = (bus_addr[SHIFT-1:0] == '0) &&
                       ((bus_addr >> SHIFT) < ADDR_W'(NUM_BYTES));
        rd_idx       = IDX_W'(bus_addr >> SHIFT);
        cmd.ctrl_wr  = bus_wr && wr_ok;
        cmd.hold_req = bus_wdata[0];
        cmd.cap_req  = bus_wr && wr_ok && bus_wdata[1];
        acc_err      = (bus_rd && !rd_ok) || (bus_wr && !wr_ok);
    end

endmodule

// File: rtl/csc_counter.sv
// Free-running cycle counter with a software hold. A hold write clears the
// count in the same edge; a release write lets it count from that edge on.
// Assumes: cmd comes from csc_decode in the same cycle.
module csc_counter
    import csc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  csc_cmd_t         cmd,
    output logic [CNT_W-1:0] cnt_o
);

    logic hold_q;
    logic hold_nxt;

    // Hold state after this cycle's control write, if any.
    always_comb hold_nxt = cmd.ctrl_wr ? cmd.hold_req : hold_q;

    // Count register and hold flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            cnt_o  <= '0;
        end else begin
            hold_q <= hold_nxt;
            cnt_o  <= hold_nxt ? '0 : cnt_o + 1'b1;
        end
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_q && !cmd.ctrl_wr) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

    // R3
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ctrl_wr && cmd.hold_req) |=> (cnt_o == '0));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !cmd.ctrl_wr) |=> (cnt_o == '0));

endmodule

// File: rtl/csc_snapshot.sv
// Snapshot register: copies the live count on a capture request and
// otherwise keeps its value, so multi-byte readback stays coherent.
// Assumes: cnt_i is the counter value before the current edge.
module csc_snapshot
    import csc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  csc_cmd_t         cmd,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] snap_o
);

    // Capture the count when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)           snap_o <= '0;
        else if (cmd.cap_req) snap_o <= cnt_i;
    end

    // R4
    snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cap_req |=> (snap_o == $past(cnt_i)));

    // R4
    snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.cap_req |=> $stable(snap_o));

endmodule

// File: rtl/csc_readback.sv
// Readback path: splits the snapshot into byte lanes and registers the
// selected lane, zero-extended, together with the error flag.
// Assumes: rd_idx is meaningful only when rd_ok is set.
module csc_readback #(
    parameter int CNT_W     = 64,
    parameter int NUM_BYTES = 8,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] snap_i,
    input  logic             bus_rd,
    input  logic             rd_ok,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             acc_err,
    output logic [31:0]      bus_rdata,
    output logic             bus_err
);

    localparam int PAD_W = NUM_BYTES * 8;

    logic [PAD_W-1:0] snap_pad;
    logic [7:0]       lane [NUM_BYTES];

    // Zero-extend the snapshot to whole bytes.
    assign snap_pad = PAD_W'(snap_i);

    // One lane per readback register.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        assign lane[g] = snap_pad[g*8 +: 8];
    end

    // Register the selected byte and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_rd && rd_ok && !acc_err) ? {24'd0, lane[rd_idx]} : '0;
            bus_err   <= acc_err;
        end
    end

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R9
    bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_ok) |=> (bus_err && bus_rdata == '0));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:8] == '0);

endmodule

// File: rtl/cyc_snap_counter.sv
// Top level: cycle counter with snapshot readback on a byte-wide register
// window. Offset 0x00 write = control (bit 0 hold, bit 1 capture); offsets
// 4*k read snapshot byte k. Read data is valid one cycle after the read.
// Assumes: CNT_W > 8 and the window of ADDR_W bits covers all readback offsets.
module cyc_snap_counter
    import csc_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err
);

    localparam int NUM_BYTES = (CNT_W + 7) / 8;
    localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    csc_cmd_t         cmd;
    logic             rd_ok;
    logic [IDX_W-1:0] rd_idx;
    logic             acc_err;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] snap;

    csc_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BYTES(NUM_BYTES),
        .IDX_W    (IDX_W)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .cmd      (cmd),
        .rd_ok    (rd_ok),
        .rd_idx   (rd_idx),
        .acc_err  (acc_err)
    );

    csc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .cnt_o(cnt)
    );

    csc_snapshot #(.CNT_W(CNT_W)) u_snapshot (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .cnt_i (cnt),
        .snap_o(snap)
    );

    csc_readback #(
        .CNT_W    (CNT_W),
        .NUM_BYTES(NUM_BYTES),
        .IDX_W    (IDX_W)
    ) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap_i   (snap),
        .bus_rd   (bus_rd),
        .rd_ok    (rd_ok),
        .rd_idx   (rd_idx),
        .acc_err  (acc_err),
        .bus_rdata(bus_rdata),
        .bus_err  (bus_err)
    );

    // R5
    both_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.cap_req && cmd.hold_req) |=> (snap == $past(cnt) && cnt == '0));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !$past(acc_err)) |-> 1'b0);

endmodule

// File: tb/tb_cyc_snap_counter.sv
// Directed bench: a 64-bit copy (dut) and a 12-bit copy (dut_s) share one
// bus stimulus. Inputs change on falling edges; outputs are sampled there.
module tb_cyc_snap_counter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic        wr;
    logic        rd;
    logic [31:0] wdata;
    logic [31:0] rdata_b, rdata_s;
    logic        err_b, err_s;
    int          n_chk  = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    cyc_snap_counter #(.CNT_W(64), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata_b), .bus_err(err_b)
    );

    cyc_snap_counter #(.CNT_W(12), .ADDR_W(8)) dut_s (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata_s), .bus_err(err_s)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // One write: occupies exactly one rising edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0; addr = '0;
    endtask

    // One read: outputs are valid on return.
    task automatic bus_read(input logic [7:0] a);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0; addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk("R2 rdata in reset", rdata_b, 0);
        chk("R2 err in reset", err_b, 0);
        rst_n = 1'b1;
        bus_read(8'h00);                     // edge 1: count 1
        chk("R2 snapshot cleared wide", rdata_b, 0);
        chk("R2 snapshot cleared narrow", rdata_s, 0);
        bus_write(8'h00, 32'h2);             // captures 1
        bus_read(8'h00);
        chk("R2 running after reset wide", rdata_b, 1);
        chk("R2 running after reset narrow", rdata_s, 1);
        bus_read(8'h1C);
        chk("R6 top byte zero wide", rdata_b, 0);
        chk("R9 narrow past last byte err", err_s, 1);
    endtask

    task automatic t_map();
        bus_write(8'h00, 32'h1);
        bus_write(8'h00, 32'h0);             // count 1
        idle(699);
        bus_write(8'h00, 32'h2);             // captures 700 = 0x2BC
        for (int k = 0; k < 8; k++) begin
            bus_read(8'(k * 4));
            chk("R6 wide byte", rdata_b, (64'd700 >> (8 * k)) & 64'hFF);
            if (k < 2) chk("R6 narrow byte", rdata_s, (64'd700 >> (8 * k)) & 64'hFF);
            else       chk("R9 narrow byte err", err_s, 1);
        end
        bus_write(8'h00, 32'h1);             // hold
        idle(5);
        bus_write(8'h00, 32'h3);             // capture while held
        bus_read(8'h00);
        chk("R3 held count wide", rdata_b, 0);
        chk("R3 held count narrow", rdata_s, 0);
    endtask

    task automatic t_stable();
        bus_write(8'h00, 32'h0);             // release: count 1
        idle(40);
        bus_write(8'h00, 32'h2);             // captures 41
        bus_read(8'h00);
        chk("R4 capture", rdata_b, 41);
        idle(100);
        bus_read(8'h00);
        chk("R7 stable while counting", rdata_b, 41);
        bus_write(8'h00, 32'h0);
        bus_read(8'h00);
        chk("R4 bit1 clear no capture", rdata_b, 41);
        idle(1);
        chk("R8 idle rdata zero", rdata_b, 0);
    endtask

    task automatic t_both();
        bus_write(8'h00, 32'h1);
        bus_write(8'h00, 32'h0);             // count 1
        idle(9);
        bus_write(8'h00, 32'h3);             // captures 10, clears
        bus_read(8'h00);
        chk("R5 pre-clear count", rdata_b, 10);
        bus_write(8'h00, 32'h3);             // captures 0
        bus_read(8'h00);
        chk("R5 counter cleared", rdata_b, 0);
        chk("R5 counter cleared narrow", rdata_s, 0);
    endtask

    task automatic t_wrap();
        bus_write(8'h00, 32'h1);
        bus_write(8'h00, 32'h0);             // count 1
        idle(4094);
        bus_write(8'h00, 32'h2);             // captures 4095
        bus_read(8'h00);
        chk("R1 all ones low narrow", rdata_s, 8'hFF);
        bus_read(8'h04);
        chk("R1 all ones high narrow", rdata_s, 8'h0F);
        chk("R6 wide byte1", rdata_b, 8'h0F);
        bus_write(8'h00, 32'h2);             // captures 4098
        bus_read(8'h00);
        chk("R1 wrapped low narrow", rdata_s, 8'h02);
        chk("R1 no wrap low wide", rdata_b, 8'h02);
        bus_read(8'h04);
        chk("R1 wrapped high narrow", rdata_s, 8'h00);
        chk("R1 no wrap high wide", rdata_b, 8'h10);
    endtask

    task automatic t_errors();
        bus_write(8'h00, 32'h1);
        bus_write(8'h00, 32'h0);             // count 1
        bus_write(8'h04, 32'h3);             // undefined write: count 2
        chk("R9 bad write err wide", err_b, 1);
        chk("R9 bad write err narrow", err_s, 1);
        idle(1);                             // count 3
        chk("R9 err one cycle", err_b, 0);
        chk("R8 rdata zero after no read", rdata_b, 0);
        bus_write(8'h00, 32'h2);             // captures 3 if ignored
        bus_read(8'h00);
        chk("R9 bad write no effect", rdata_b, 3);
        bus_read(8'h20);
        chk("R9 out of range err", err_b, 1);
        chk("R9 out of range data", rdata_b, 0);
        bus_read(8'h02);
        chk("R9 unaligned err", err_b, 1);
        chk("R9 unaligned data", rdata_b, 0);
        bus_read(8'h08);
        chk("R6 wide byte2 legal", err_b, 0);
        chk("R9 narrow byte2 err", err_s, 1);
        bus_read(8'hFC);
        chk("R9 far offset err", err_b, 1);
        bus_read(8'h00);
        chk("R9 bad reads no effect", rdata_b, 3);
        chk("R8 no err on legal read", err_b, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
        @(negedge clk);
        t_reset();
        t_map();
        t_stable();
        t_both();
        t_wrap();
        t_errors();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule